// File: doc/BRIEF.md
# Incremental quadrature and commutation generator

This block turns a stream of 16-bit absolute shaft angles into the signals an incremental encoder would give. It makes A/B quadrature with an index pulse, and U/V/W commutation signals that imitate three Hall sensors. The counts per revolution, the index width and the pole-pair count are set by configuration inputs. A direction input chooses which rotation sense counts up. A hysteresis band, given in angle LSBs, keeps the quadrature outputs from toggling when the angle jitters near a transition.

Angles arrive over a valid/ready stream. The block never applies back-pressure. `in_ready` is low only while reset is asserted and is high at all other times. A beat is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The outputs show that angle from the following cycle on. When no beat is taken, the outputs keep their values. Until the first beat after reset, every output stays at its power-up idle level. Configuration inputs are plain levels and are expected to be held steady while angles are streaming.

Top module: `incr_encoder_out`

## Requirements
- R1: After reset, and until the first angle is accepted, q_a, q_b and q_i are 1 and c_u, c_v and c_w are 0. in_ready is 0 while rst_n is low and 1 from the first clock edge after release.
- R2: An angle is accepted on a clock edge where in_valid and in_ready are both 1. The outputs reflect it one cycle later. When in_valid is 0, the input angle is ignored and all outputs hold.
- R3: cfg_cpr = k (0..7) gives N = 32·2^k counts per revolution, and codes 8..15 act as 4096. The quarter index is q = pos >> (14 − log2 N), which gives 4N quarters per revolution.
- R4: Let the held quarter be h. Then (q_a,q_b) is 11, 01, 00, 10 for h mod 4 = 0, 1, 2, 3. In the up direction, A changes first and B follows.
- R5: With cfg_ccw = 0, pos = angle. With cfg_ccw = 1, pos = (65536 − angle) mod 65536.
- R6: q_i is 1 exactly when h ≤ cfg_iwidth. The index therefore covers 1 to 4 quarters from the zero angle, which is 90, 180, 270 or 360 electrical degrees.
- R7: The hysteresis band H in LSBs is 0 for cfg_hyst = 0, 2^(c−1) for codes c = 1..9, and 256 for codes 10..15.
- R8: The first accepted angle loads h = q directly. After that, let Q = 4N. If quarter(pos − H) is 1..Q/2 quarters ahead of h, h moves to it. Otherwise, if quarter(pos + H) is 1..Q/2−1 quarters behind h, h moves to it. Otherwise h holds. With H = 0, h always equals q.
- R9: Let P = cfg_poles + 1 and e = (pos·P) mod 65536. The sector is s = (6·e) >> 16. {c_u,c_v,c_w} is 101, 100, 110, 010, 011, 001 for s = 0..5, so exactly one output changes at each sector boundary.
- R10: At pos = 0, both c_u and q_i are 1, so U's high phase and the index both start at the zero angle.
- R11: When cfg_uvw_en is 0, c_u, c_v and c_w are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Angle beat valid |
| in_ready | output | 1 | Block accepts angles (high outside reset) |
| in_angle | input | 16 | Absolute angle, full turn = 65536 |
| cfg_cpr | input | 4 | Counts-per-revolution code |
| cfg_iwidth | input | 2 | Index width code |
| cfg_poles | input | 3 | Pole-pair count minus one |
| cfg_ccw | input | 1 | 1: count up for counterclockwise rotation |
| cfg_hyst | input | 4 | Hysteresis band code |
| cfg_uvw_en | input | 1 | 1: commutation outputs active |
| q_a | output | 1 | Quadrature A |
| q_b | output | 1 | Quadrature B |
| q_i | output | 1 | Index |
| c_u | output | 1 | Commutation U |
| c_v | output | 1 | Commutation V |
| c_w | output | 1 | Commutation W |

## Verification
The held quarter index is the only long-lived state in the quadrature path. If it is wrong, the A/B phase or the index level differs from the arithmetic value in the first cycle after the beat that corrupts it. A hysteresis error shows up as a move that comes one beat too early or too late during a slow walk across a transition. A wrong sector register shows as an illegal or shifted U/V/W pattern at the next accepted angle. An idle flag that clears too early breaks the 111/000 power-up levels before the first beat.

// File: rtl/incr_enc_pkg.sv
package incr_enc_pkg;
  localparam int ANG_W       = 16;
  localparam int MIN_CPR_LOG = 5;
  localparam int CPR_CODES   = 8;
  localparam int HYST_CODES  = 9;
  localparam int SH_W        = 5;
  localparam int SECT_W      = 3;

  // right shift that turns a direction-adjusted angle into a quarter index
  function automatic logic [SH_W-1:0] quarter_shift(input logic [3:0] code);
    int k;
    k = code[3] ? (CPR_CODES - 1) : int'(code[2:0]);
    return SH_W'(ANG_W - MIN_CPR_LOG - 2 - k);
  endfunction

  // hysteresis band in angle LSBs
  function automatic logic [ANG_W-1:0] hyst_lsb(input logic [3:0] code);
    int c;
    c = (int'(code) > HYST_CODES) ? HYST_CODES : int'(code);
    if (c == 0) return '0;
    return ANG_W'(1) << (c - 1);
  endfunction
endpackage

// File: rtl/enc_quad_track.sv
module enc_quad_track
  import incr_enc_pkg::*;
#(
  parameter int AW = ANG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          first,
  input  logic [AW-1:0] pos,
  input  logic [3:0]    cfg_cpr,
  input  logic [3:0]    cfg_hyst,
  input  logic [1:0]    cfg_iwidth,
  output logic          qa,
  output logic          qb,
  output logic          qi
);
  logic [SH_W-1:0] sh;
  logic [AW-1:0]   band, mask, half;
  logic [AW-1:0]   raw, c_up, c_dn, d_up, d_dn;
  logic [AW-1:0]   held, nxt;

  assign sh   = quarter_shift(cfg_cpr);
  assign band = AW'(hyst_lsb(cfg_hyst));
  assign mask = {AW{1'b1}} >> sh;
  assign half = (mask >> 1) + AW'(1);

  assign raw  = pos >> sh;
  assign c_up = (pos - band) >> sh;
  assign c_dn = (pos + band) >> sh;
  assign d_up = (c_up - held) & mask;
  assign d_dn = (held - c_dn) & mask;

  always_comb begin
    if (first)                             nxt = raw;
    else if (d_up != '0 && d_up <= half)   nxt = c_up;
    else if (d_dn != '0 && d_dn <  half)   nxt = c_dn;
    else                                   nxt = held;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (take) held <= nxt;
  end

  assign qa = (held[1:0] == 2'd0) || (held[1:0] == 2'd3);
  assign qb = (held[1:0] == 2'd0) || (held[1:0] == 2'd1);
  assign qi = (held <= AW'(cfg_iwidth));

  // R2: no accepted beat, no movement of the held quarter
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(held));
  // R8: zero band tracks the raw quarter exactly
  a_r8_exact_no_band: assert property (@(posedge clk) disable iff (!rst_n)
    take && cfg_hyst == 4'd0 |=> held == $past(raw));
  // R8: a move lands only on one of the two band probes
  a_r8_move_targets: assert property (@(posedge clk) disable iff (!rst_n)
    take && !first |=> held == $past(held) || held == $past(c_up) || held == $past(c_dn));
endmodule

// File: rtl/enc_comm_sector.sv
module enc_comm_sector
  import incr_enc_pkg::*;
#(
  parameter int AW = ANG_W,
  parameter int SW = SECT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] pos,
  input  logic [2:0]    cfg_poles,
  output logic          su,
  output logic          sv,
  output logic          sw
);
  localparam int PW = AW + 4;
  localparam int XW = AW + SW;

  logic [3:0]    npp;
  logic [PW-1:0] prod;
  logic [AW-1:0] elec;
  logic [XW-1:0] six;
  logic [SW-1:0] sect_n, sect;

  assign npp    = {1'b0, cfg_poles} + 4'd1;
  assign prod   = {4'b0, pos} * {{AW{1'b0}}, npp};
  assign elec   = prod[AW-1:0];
  assign six    = {{SW{1'b0}}, elec} * XW'(6);
  assign sect_n = six[XW-1:AW];

  always_ff @(posedge clk) begin
    if (!rst_n)    sect <= '0;
    else if (take) sect <= sect_n;
  end

  assign su = (sect <= SW'(2));
  assign sv = (sect >= SW'(2)) && (sect <= SW'(4));
  assign sw = (sect >= SW'(4)) || (sect == SW'(0));

  // R9: the sector register holds between beats
  a_r9_sector_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(sect));
  // R9: sector index stays within one pole pair
  a_r9_sector_range: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> sect < SW'(6));
endmodule

// File: rtl/incr_encoder_out.sv
module incr_encoder_out
  import incr_enc_pkg::*;
#(
  parameter int AW = ANG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_angle,
  input  logic [3:0]    cfg_cpr,
  input  logic [1:0]    cfg_iwidth,
  input  logic [2:0]    cfg_poles,
  input  logic          cfg_ccw,
  input  logic [3:0]    cfg_hyst,
  input  logic          cfg_uvw_en,
  output logic          q_a,
  output logic          q_b,
  output logic          q_i,
  output logic          c_u,
  output logic          c_v,
  output logic          c_w
);
  logic          live, take, first;
  logic [AW-1:0] pos;
  logic          ta, tb, ti, su, sv, sw;

  assign take  = in_valid && in_ready;
  assign first = take && !live;
  assign pos   = cfg_ccw ? (AW'(0) - in_angle) : in_angle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      live     <= 1'b0;
    end else begin
      in_ready <= 1'b1;
      if (take) live <= 1'b1;
    end
  end

  enc_quad_track #(.AW(AW)) u_track (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .pos(pos),
    .cfg_cpr(cfg_cpr), .cfg_hyst(cfg_hyst), .cfg_iwidth(cfg_iwidth),
    .qa(ta), .qb(tb), .qi(ti)
  );

  enc_comm_sector #(.AW(AW)) u_comm (
    .clk(clk), .rst_n(rst_n), .take(take), .pos(pos), .cfg_poles(cfg_poles),
    .su(su), .sv(sv), .sw(sw)
  );

  assign q_a = live ? ta : 1'b1;
  assign q_b = live ? tb : 1'b1;
  assign q_i = live ? ti : 1'b1;
  assign c_u = live && cfg_uvw_en && su;
  assign c_v = live && cfg_uvw_en && sv;
  assign c_w = live && cfg_uvw_en && sw;

  // R1: idle levels until the first beat
  a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> q_a && q_b && q_i && !c_u && !c_v && !c_w);
  // R11: commutation off means all three low
  a_r11_uvw_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_uvw_en |-> !c_u && !c_v && !c_w);
  // R9: never all-high or all-low while commutating
  a_r9_legal_hall: assert property (@(posedge clk) disable iff (!rst_n)
    live && cfg_uvw_en |-> (c_u || c_v || c_w) && !(c_u && c_v && c_w));
  // R6: a one-quarter index sits on the A=B=1 quarter
  a_r6_index_quarter0: assert property (@(posedge clk) disable iff (!rst_n)
    live && q_i && cfg_iwidth == 2'd0 |-> q_a && q_b);
endmodule

// File: tb/incr_encoder_out_bench.sv
module incr_encoder_out_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_angle = '0;
  logic [3:0] cfg_cpr = '0;
  logic [1:0] cfg_iwidth = '0;
  logic [2:0] cfg_poles = '0;
  logic cfg_ccw = 1'b0;
  logic [3:0] cfg_hyst = '0;
  logic cfg_uvw_en = 1'b1;
  logic q_a, q_b, q_i, c_u, c_v, c_w;

  int total = 0;
  int bad = 0;
  int mheld = 0;
  bit mlive = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  incr_encoder_out u_incr_encoder_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_angle(in_angle), .cfg_cpr(cfg_cpr), .cfg_iwidth(cfg_iwidth),
    .cfg_poles(cfg_poles), .cfg_ccw(cfg_ccw), .cfg_hyst(cfg_hyst),
    .cfg_uvw_en(cfg_uvw_en), .q_a(q_a), .q_b(q_b), .q_i(q_i),
    .c_u(c_u), .c_v(c_v), .c_w(c_w)
  );

  function automatic logic [5:0] outs();
    return {q_a, q_b, q_i, c_u, c_v, c_w};
  endfunction

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b angle=%0d", tag, got, exp, in_angle);
    end
  endtask

  function automatic int shf();
    int k;
    k = cfg_cpr[3] ? 7 : int'(cfg_cpr[2:0]);
    return 9 - k;
  endfunction

  function automatic int band();
    int c;
    c = (int'(cfg_hyst) > 9) ? 9 : int'(cfg_hyst);
    return (c == 0) ? 0 : (1 << (c - 1));
  endfunction

  function automatic int posf(input int ang);
    return cfg_ccw ? ((65536 - ang) & 65535) : ang;
  endfunction

  function automatic int model_next(input int p);
    int sh, mask, half, raw, cu, cd, du, dd, h;
    sh = shf(); h = band();
    mask = 65535 >> sh; half = (mask >> 1) + 1;
    raw = p >> sh;
    cu = ((p - h) & 65535) >> sh;
    cd = ((p + h) & 65535) >> sh;
    du = (cu - mheld) & mask;
    dd = (mheld - cd) & mask;
    if (!mlive) return raw;
    if (du != 0 && du <= half) return cu;
    if (dd != 0 && dd < half) return cd;
    return mheld;
  endfunction

  function automatic logic [5:0] expect_vec(input int p);
    logic a, b, ix;
    logic [2:0] hall;
    int e, s;
    a  = (mheld % 4 == 0) || (mheld % 4 == 3);
    b  = (mheld % 4 == 0) || (mheld % 4 == 1);
    ix = (mheld <= int'(cfg_iwidth));
    e  = (p * (int'(cfg_poles) + 1)) % 65536;
    s  = (e * 6) >> 16;
    case (s)
      0: hall = 3'b101; 1: hall = 3'b100; 2: hall = 3'b110;
      3: hall = 3'b010; 4: hall = 3'b011; default: hall = 3'b001;
    endcase
    if (!cfg_uvw_en) hall = 3'b000;
    return {a, b, ix, hall};
  endfunction

  task automatic step(input string tag, input int ang);
    int p;
    in_angle = 16'(ang);
    in_valid = 1'b1;
    p = posf(ang);
    mheld = model_next(p);
    mlive = 1;
    @(negedge clk);
    chk(tag, outs(), expect_vec(p));
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mlive = 0; mheld = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] snap;
    @(negedge clk);
    do_reset();
    // R1: idle levels and ready after reset
    chk("R1 idle", outs(), 6'b111000);
    chk("R1 ready", {5'b0, in_ready}, 6'b000001);
    @(negedge clk);
    chk("R1 idle held", outs(), 6'b111000);

    // R3 R4 R6: counts per revolution sweep, no band
    for (int code = 0; code < 9; code++) begin
      cfg_cpr = 4'(code);
      cfg_iwidth = 2'(code % 4);
      for (int ang = 0; ang < 65536; ang += 53) step("R3 R4 R6 sweep", ang);
    end

    // R10: U and index both high at zero
    cfg_cpr = 4'd4; cfg_iwidth = 2'd0;
    step("R10 zero", 0);
    chk("R10 u and i", {3'b0, q_i, c_u, 1'b0}, 6'b000110);
    step("R10 end of turn", 65535);
    chk("R10 below zero", {3'b0, q_i, c_u, 1'b0}, 6'b000000);

    // R9: commutation sectors for every pole-pair count
    cfg_cpr = 4'd3;
    for (int pp = 0; pp < 8; pp++) begin
      cfg_poles = 3'(pp);
      for (int ang = 0; ang < 65536; ang += 101) step("R9 sector", ang);
    end

    // R5: reverse counting sense
    cfg_ccw = 1'b1; cfg_cpr = 4'd2; cfg_poles = 3'd2; cfg_iwidth = 2'd3;
    for (int ang = 0; ang < 65536; ang += 211) step("R5 reverse", ang);
    cfg_ccw = 1'b0;

    // R11: commutation disabled
    cfg_uvw_en = 1'b0;
    for (int ang = 0; ang < 65536; ang += 4099) step("R11 uvw off", ang);
    cfg_uvw_en = 1'b1;

    // R2: angle ignored while valid is low
    step("R2 base", 12345);
    snap = outs();
    in_valid = 1'b0;
    in_angle = 16'd40000;
    repeat (3) @(negedge clk);
    chk("R2 hold", outs(), snap);

    // R7 R8: band 32 LSB at 32 CPR (quarter width 512)
    do_reset();
    cfg_cpr = 4'd0; cfg_hyst = 4'd6; cfg_poles = 3'd0; cfg_iwidth = 2'd0;
    step("R8 load", 0);
    step("R8 inside band", 522);
    chk("R8 stay q0", {outs()[5:4], 4'b0}, 6'b110000);
    step("R7 band edge", 544);
    chk("R7 move q1", {outs()[5:4], 4'b0}, 6'b010000);
    step("R8 back inside", 502);
    chk("R8 stay q1", {outs()[5:4], 4'b0}, 6'b010000);
    step("R8 back out", 479);
    chk("R8 return q0", {outs()[5:4], 4'b0}, 6'b110000);

    // R8: band wider than a quarter at 4096 CPR
    do_reset();
    cfg_cpr = 4'd7; cfg_hyst = 4'd9;
    step("R8 wide load", 1000);
    step("R8 wide hold", 1256);
    chk("R8 wide q250", {outs()[5:4], 4'b0}, 6'b000000);
    step("R8 wide move", 1260);
    chk("R8 wide q251", {outs()[5:4], 4'b0}, 6'b100000);

    // R7 R8: slow walks with every band code
    for (int hc = 0; hc < 16; hc++) begin
      int ang;
      int lcg;
      do_reset();
      cfg_hyst = 4'(hc);
      cfg_cpr = 4'(hc % 8);
      ang = 65000; lcg = hc * 7919 + 13;
      for (int n = 0; n < 400; n++) begin
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        ang = (ang + ((lcg >> 8) % 161) - 80) & 65535;
        step("R7 R8 walk", ang);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule